// File: doc/BRIEF.md
# Indirect Interrupt-Controller Register Window

This block is the register front end of an I/O interrupt controller with 24 input pins. The CPU reaches everything through two addresses. One is an 8-bit select register. The other is a 32-bit data window. The value in the select register decides what the window reaches: the controller ID, a read-only version word, an arbitration word, or one 32-bit half of a 64-bit redirection entry.

The block stores the redirection table, the 4-bit ID and the per-pin pending-request bits. The whole table is presented to the delivery logic as a flat vector. Delivery and end-of-interrupt handling sit outside the block. In return, the block gets pulses that set or clear pending bits and that set an entry's remote-IRR bit.

Every table write has side effects, reported as one-cycle strobes in the cycle after the write:
- a table-write pulse carrying the entry index;
- a mask-change pulse carrying the pin and the new mask value;
- a service request for a level-triggered pin whose pending bit is set.

Top module: `irq_window`

## Requirements
- R1: After reset, the select register and the ID read 0, every pending bit is 0, and every entry reads 0x00010000 (low half) and 0 (high half), so only the mask bit is set. No strobe is active.
- R2: Address decode uses addr_i[7:4]. A value of 0 is the select register; a write to it keeps wdata_i[7:0] and reads back zero-extended.
- R3: Select 0x01 reads the version word {8'h00, pin count - 1, 8'h00, version code}, which is 0x00170011 by default. Writes to it are ignored.
- R4: A write with select 0x00 stores wdata_i[27:24] as the ID. Selects 0x00 and 0x02 both read the ID in bits 27:24 with all other bits 0. Writes with select 0x02 are ignored.
- R5: For select values of 0x10 and above, the entry index is (select - 0x10) >> 1. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. The entry layout is:
  - vector in 7:0;
  - delivery mode in 10:8;
  - destination mode in 11;
  - delivery status in 12;
  - polarity in 13;
  - remote-IRR in 14;
  - trigger mode in 15 (1 = level);
  - mask in 16;
  - destination in 63:56.
- R6: A select whose entry index is at or beyond the pin count, or a select from 0x03 to 0x0F, reads all ones. A write through such a select changes nothing and raises no strobe.
- R7: A low-half write forces that entry's remote-IRR bit to 0 whatever the data holds. A high-half write leaves it unchanged. A pulse on rirr_set_i sets it.
- R8: A table write that changes an entry's mask bit raises mask_chg_o for exactly one cycle, with mask_pin_o set to the pin and mask_val_o set to the new mask value. A write that leaves the mask bit unchanged raises no mask strobe.
- R9: Every accepted table write raises tbl_wr_o for one cycle with the entry index on tbl_idx_o.
- R10: After a table write, if the written entry is level-triggered and its pin's pending bit is set, svc_req_o pulses for one cycle with the pin on svc_pin_o. There is no request for edge-triggered entries or when the pending bit is clear.
- R11: Reads of decode slots other than 0 and 1 return 0. Writes to them have no effect.
- R12: entries_o[64*i +: 64] always equals entry i as read through the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irr_set_i | input | 24 | Per-pin pending-request set pulses |
| irr_clr_i | input | 24 | Per-pin pending-request clear pulses |
| rirr_set_i | input | 24 | Per-pin remote-IRR set pulses from delivery logic |
| entries_o | output | 1536 | Full redirection table, entry i at bits 64*i +: 64 |
| tbl_wr_o | output | 1 | Table-write strobe |
| tbl_idx_o | output | 5 | Entry index of the table write |
| mask_chg_o | output | 1 | Mask-change strobe |
| mask_pin_o | output | 5 | Pin whose mask changed |
| mask_val_o | output | 1 | New mask value |
| svc_req_o | output | 1 | Service request strobe |
| svc_pin_o | output | 5 | Pin to service |

## Verification
The bench targets the index arithmetic at its edges: the last valid entry (select 0x3F) and the first invalid one (0x40). An off-by-one there would read a phantom entry or corrupt a neighbour. It also checks the low-versus-high asymmetry on remote-IRR: a design that copied bit 14 from the write data, or cleared it on a high-half write, would lose or invent an outstanding level interrupt. It drives writes that rewrite an unchanged mask, level entries with and without a pending bit, and an edge entry with a pending bit. Each of these exposes a spurious or missing mask strobe or service request.

// File: rtl/irqwin_pkg.sv
package irqwin_pkg;
  localparam int DATA_W = 32;
  localparam int ENT_W  = 64;
  localparam int B_RIRR = 14;
  localparam int B_TRIG = 15;
  localparam int B_MASK = 16;
  localparam logic [ENT_W-1:0] ENT_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    REG_ID,
    REG_VER,
    REG_ARB,
    REG_TBL,
    REG_BAD
  } reg_kind_e;
endpackage

// File: rtl/win_decode.sv
module win_decode
  import irqwin_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic [7:0]       sel_i,
  output reg_kind_e        kind_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hi_o
);
  logic [7:0] off;
  logic [6:0] raw;

  always_comb begin
    off   = sel_i - 8'h10;
    raw   = off[7:1];
    hi_o  = sel_i[0];
    idx_o = raw[IDX_W-1:0];
    if (sel_i == 8'h00)                                   kind_o = REG_ID;
    else if (sel_i == 8'h01)                              kind_o = REG_VER;
    else if (sel_i == 8'h02)                              kind_o = REG_ARB;
    else if (sel_i >= 8'h10 && 32'(raw) < NPINS)          kind_o = REG_TBL;
    else                                                  kind_o = REG_BAD;
  end
endmodule

// File: rtl/redir_slot.sv
module redir_slot
  import irqwin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rirr_set_i,
  output logic [ENT_W-1:0]  ent_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_o <= ENT_RST;
    end else begin
      if (wr_hi_i) ent_o[63:32] <= wdata_i;
      if (wr_lo_i) begin
        ent_o[31:0]   <= wdata_i;
        ent_o[B_RIRR] <= 1'b0;  // low write always retires remote-IRR
      end else if (rirr_set_i) begin
        ent_o[B_RIRR] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wr_effects.sv
module wr_effects
  import irqwin_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ok_i,
  input  logic              hi_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ENT_W-1:0]  cur_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irr_bit_i,
  output logic              tbl_wr_o,
  output logic [IDX_W-1:0]  tbl_idx_o,
  output logic              mask_chg_o,
  output logic [IDX_W-1:0]  mask_pin_o,
  output logic              mask_val_o,
  output logic              svc_req_o,
  output logic [IDX_W-1:0]  svc_pin_o
);
  logic [ENT_W-1:0] nxt;

  always_comb begin
    nxt = cur_i;
    if (hi_i) nxt[63:32] = wdata_i;
    else      nxt[31:0]  = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_wr_o   <= 1'b0;
      tbl_idx_o  <= '0;
      mask_chg_o <= 1'b0;
      mask_pin_o <= '0;
      mask_val_o <= 1'b0;
      svc_req_o  <= 1'b0;
      svc_pin_o  <= '0;
    end else begin
      tbl_wr_o   <= wr_ok_i;
      mask_chg_o <= wr_ok_i && (nxt[B_MASK] != cur_i[B_MASK]);
      svc_req_o  <= wr_ok_i && nxt[B_TRIG] && irr_bit_i;
      if (wr_ok_i) begin
        tbl_idx_o  <= idx_i;
        mask_pin_o <= idx_i;
        mask_val_o <= nxt[B_MASK];
        svc_pin_o  <= idx_i;
      end
    end
  end
endmodule

// File: rtl/irq_window.sv
module irq_window
  import irqwin_pkg::*;
#(
  parameter int         NPINS    = 24,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int        IDX_W    = $clog2(NPINS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [7:0]             addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  input  logic [NPINS-1:0]       irr_set_i,
  input  logic [NPINS-1:0]       irr_clr_i,
  input  logic [NPINS-1:0]       rirr_set_i,
  output logic [NPINS*64-1:0]    entries_o,
  output logic                   tbl_wr_o,
  output logic [IDX_W-1:0]       tbl_idx_o,
  output logic                   mask_chg_o,
  output logic [IDX_W-1:0]       mask_pin_o,
  output logic                   mask_val_o,
  output logic                   svc_req_o,
  output logic [IDX_W-1:0]       svc_pin_o
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VER_CODE};

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  logic [NPINS-1:0] irr_q;
  logic [ENT_W-1:0] tbl [NPINS];
  reg_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic             hi;
  logic             at_sel, at_win, win_wr, tbl_wr_ok;
  logic [ENT_W-1:0] cur_ent;
  logic             cur_irr;

  assign at_sel    = (addr_i[7:4] == 4'h0);
  assign at_win    = (addr_i[7:4] == 4'h1);
  assign win_wr    = wr_en_i && at_win;
  assign tbl_wr_ok = win_wr && (kind == REG_TBL);

  win_decode #(.NPINS(NPINS), .IDX_W(IDX_W)) u_dec (
    .sel_i (sel_q),
    .kind_o(kind),
    .idx_o (idx),
    .hi_o  (hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 8'h00;
      id_q  <= 4'h0;
      irr_q <= '0;
    end else begin
      if (wr_en_i && at_sel)          sel_q <= wdata_i[7:0];
      if (win_wr && kind == REG_ID)   id_q  <= wdata_i[27:24];
      irr_q <= (irr_q & ~irr_clr_i) | irr_set_i;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_slot
    logic sel_me;
    assign sel_me = tbl_wr_ok && (32'(idx) == i);
    redir_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_lo_i   (sel_me && !hi),
      .wr_hi_i   (sel_me && hi),
      .wdata_i   (wdata_i),
      .rirr_set_i(rirr_set_i[i]),
      .ent_o     (tbl[i])
    );
    assign entries_o[i*ENT_W +: ENT_W] = tbl[i];
  end

  always_comb begin
    cur_ent = ENT_RST;
    cur_irr = 1'b0;
    for (int i = 0; i < NPINS; i++) begin
      if (32'(idx) == i) begin
        cur_ent = tbl[i];
        cur_irr = irr_q[i];
      end
    end
  end

  wr_effects #(.IDX_W(IDX_W)) u_fx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ok_i   (tbl_wr_ok),
    .hi_i      (hi),
    .idx_i     (idx),
    .cur_i     (cur_ent),
    .wdata_i   (wdata_i),
    .irr_bit_i (cur_irr),
    .tbl_wr_o  (tbl_wr_o),
    .tbl_idx_o (tbl_idx_o),
    .mask_chg_o(mask_chg_o),
    .mask_pin_o(mask_pin_o),
    .mask_val_o(mask_val_o),
    .svc_req_o (svc_req_o),
    .svc_pin_o (svc_pin_o)
  );

  always_comb begin
    rdata_o = 32'h0;
    if (at_sel) begin
      rdata_o = {24'h0, sel_q};
    end else if (at_win) begin
      case (kind)
        REG_ID, REG_ARB: rdata_o = {4'h0, id_q, 24'h0};
        REG_VER:         rdata_o = VER_WORD;
        REG_TBL:         rdata_o = hi ? cur_ent[63:32] : cur_ent[31:0];
        default:         rdata_o = 32'hFFFF_FFFF;
      endcase
    end
  end
endmodule

// File: rtl/irq_window_chk.sv
module irq_window_chk #(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [7:0]         addr_i,
  input logic [7:0]         sel_q,
  input logic [NPINS*64-1:0] entries_o,
  input logic               tbl_wr_o,
  input logic [IDX_W-1:0]   tbl_idx_o,
  input logic               mask_chg_o,
  input logic [IDX_W-1:0]   mask_pin_o,
  input logic               mask_val_o,
  input logic               svc_req_o,
  input logic [IDX_W-1:0]   svc_pin_o
);
  logic [7:0] off;
  logic       lo_wr;
  logic       lo_wr_q;
  logic [6:0] lo_pin_q;

  assign off   = sel_q - 8'h10;
  assign lo_wr = wr_en_i && addr_i[7:4] == 4'h1 && sel_q >= 8'h10 && !sel_q[0]
                 && 32'(off[7:1]) < NPINS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_wr_q  <= 1'b0;
      lo_pin_q <= '0;
    end else begin
      lo_wr_q  <= lo_wr;
      lo_pin_q <= off[7:1];
    end
  end

  // R7
  rirr_lo_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_q |-> !entries_o[32'(lo_pin_q)*64 + 14]);

  // R8
  mask_strobe_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_chg_o |-> (tbl_wr_o && tbl_idx_o == mask_pin_o));

  // R8
  mask_val_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_chg_o |-> (entries_o[32'(mask_pin_o)*64 + 16] == mask_val_o));

  // R10
  svc_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_req_o |-> (tbl_wr_o && svc_pin_o == tbl_idx_o && entries_o[32'(svc_pin_o)*64 + 15]));

  // R9
  tbl_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_o |-> (32'(tbl_idx_o) < NPINS));
endmodule

bind irq_window irq_window_chk #(.NPINS(NPINS), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .sel_q     (sel_q),
  .entries_o (entries_o),
  .tbl_wr_o  (tbl_wr_o),
  .tbl_idx_o (tbl_idx_o),
  .mask_chg_o(mask_chg_o),
  .mask_pin_o(mask_pin_o),
  .mask_val_o(mask_val_o),
  .svc_req_o (svc_req_o),
  .svc_pin_o (svc_pin_o)
);

// File: tb/tb_irq_window.sv
module tb_irq_window;
  localparam int NP = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [7:0]    addr_i = 8'h00;
  logic [31:0]   wdata_i = 32'h0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] irr_set_i = '0;
  logic [NP-1:0] irr_clr_i = '0;
  logic [NP-1:0] rirr_set_i = '0;
  logic [NP*64-1:0] entries_o;
  logic          tbl_wr_o, mask_chg_o, mask_val_o, svc_req_o;
  logic [4:0]    tbl_idx_o, mask_pin_o, svc_pin_o;

  int n_chk = 0;
  int n_bad = 0;

  logic       s_tbl, s_mchg, s_mval, s_svc;
  logic [4:0] s_tidx, s_mpin, s_spin;

  always #2 clk_i = ~clk_i;

  irq_window dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irr_set_i(irr_set_i),
    .irr_clr_i(irr_clr_i), .rirr_set_i(rirr_set_i), .entries_o(entries_o),
    .tbl_wr_o(tbl_wr_o), .tbl_idx_o(tbl_idx_o), .mask_chg_o(mask_chg_o),
    .mask_pin_o(mask_pin_o), .mask_val_o(mask_val_o), .svc_req_o(svc_req_o),
    .svc_pin_o(svc_pin_o)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    s_tbl = tbl_wr_o;    s_tidx = tbl_idx_o;
    s_mchg = mask_chg_o; s_mpin = mask_pin_o; s_mval = mask_val_o;
    s_svc = svc_req_o;   s_spin = svc_pin_o;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic win_wr(input logic [7:0] sel, input logic [31:0] d);
    bus_wr(8'h00, {24'h0, sel});
    bus_wr(8'h10, d);
  endtask

  task automatic win_rd(input logic [7:0] sel, output logic [31:0] d);
    bus_wr(8'h00, {24'h0, sel});
    bus_rd(8'h10, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(8'h00, d);
    check(d == 0, "R1 select", d, 0);
    win_rd(8'h00, d);
    check(d == 0, "R1 id", d, 0);
    win_rd(8'h10, d);
    check(d == 32'h0001_0000, "R1 entry0 lo", d, 32'h0001_0000);
    win_rd(8'h3F, d);
    check(d == 0, "R1 entry23 hi", d, 0);
    check(!tbl_wr_o && !mask_chg_o && !svc_req_o, "R1 strobes", 0, 0);
    check(entries_o[23*64 +: 64] == 64'h1_0000, "R12 reset entry23",
          entries_o[23*64 +: 64], 64'h1_0000);
  endtask

  task automatic t_select;
    logic [31:0] d;
    bus_wr(8'h00, 32'hDEAD_01AB);
    bus_rd(8'h00, d);
    check(d == 32'hAB, "R2 select low byte", d, 32'hAB);
    bus_rd(8'h0C, d);
    check(d == 32'hAB, "R2 decode on 16B", d, 32'hAB);
  endtask

  task automatic t_version;
    logic [31:0] d;
    win_rd(8'h01, d);
    check(d == 32'h0017_0011, "R3 version", d, 32'h0017_0011);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, d);
    check(d == 32'h0017_0011, "R3 version write ignored", d, 32'h0017_0011);
  endtask

  task automatic t_id;
    logic [31:0] d;
    win_wr(8'h00, 32'h5F12_3456);
    bus_rd(8'h10, d);
    check(d == 32'h0F00_0000, "R4 id", d, 32'h0F00_0000);
    win_rd(8'h02, d);
    check(d == 32'h0F00_0000, "R4 arb reads id", d, 32'h0F00_0000);
    bus_wr(8'h10, 32'h0300_0000);
    win_rd(8'h00, d);
    check(d == 32'h0F00_0000, "R4 arb write ignored", d, 32'h0F00_0000);
  endtask

  task automatic t_entry;
    logic [31:0] d;
    win_wr(8'h1A, 32'h0000_A0F3);
    check(s_mchg && s_mpin == 5 && s_mval == 1'b0, "R8 unmask strobe",
          {s_mchg, s_mpin, s_mval}, {1'b1, 5'd5, 1'b0});
    check(s_tbl && s_tidx == 5, "R9 tbl strobe", {s_tbl, s_tidx}, {1'b1, 5'd5});
    check(!s_svc, "R10 no svc without pending", s_svc, 0);
    @(negedge clk_i);
    check(!mask_chg_o && !tbl_wr_o, "R8 one cycle", {mask_chg_o, tbl_wr_o}, 0);
    win_wr(8'h1B, 32'h7E00_0000);
    check(!s_mchg, "R8 hi write no mask change", s_mchg, 0);
    win_rd(8'h1A, d);
    check(d == 32'h0000_A0F3, "R5 lo half", d, 32'h0000_A0F3);
    win_rd(8'h1B, d);
    check(d == 32'h7E00_0000, "R5 hi half", d, 32'h7E00_0000);
    check(entries_o[5*64 +: 64] == 64'h7E00_0000_0000_A0F3, "R12 entry5",
          entries_o[5*64 +: 64], 64'h7E00_0000_0000_A0F3);
    check(entries_o[4*64 +: 64] == 64'h1_0000, "R5 neighbour untouched",
          entries_o[4*64 +: 64], 64'h1_0000);
  endtask

  task automatic t_rirr;
    logic [31:0] d;
    @(negedge clk_i); rirr_set_i[5] = 1'b1;
    @(negedge clk_i); rirr_set_i[5] = 1'b0;
    win_rd(8'h1A, d);
    check(d == 32'h0000_E0F3, "R7 remote set", d, 32'h0000_E0F3);
    win_wr(8'h1B, 32'h7E00_0000);
    win_rd(8'h1A, d);
    check(d == 32'h0000_E0F3, "R7 hi keeps remote", d, 32'h0000_E0F3);
    win_wr(8'h1A, 32'h0000_E0F3);
    bus_rd(8'h10, d);
    check(d == 32'h0000_A0F3, "R7 lo clears remote", d, 32'h0000_A0F3);
    check(!s_mchg, "R8 same mask no strobe", s_mchg, 0);
  endtask

  task automatic t_service;
    @(negedge clk_i); irr_set_i[5] = 1'b1; irr_set_i[6] = 1'b1;
    @(negedge clk_i); irr_set_i = '0;
    win_wr(8'h1B, 32'h7E00_0000);
    check(s_svc && s_spin == 5, "R10 level pending svc", {s_svc, s_spin}, {1'b1, 5'd5});
    @(negedge clk_i);
    check(!svc_req_o, "R10 svc one cycle", svc_req_o, 0);
    win_wr(8'h1C, 32'h0000_0040);
    check(!s_svc, "R10 edge no svc", s_svc, 0);
    check(s_mchg && s_mpin == 6, "R8 pin6 unmask", {s_mchg, s_mpin}, {1'b1, 5'd6});
    win_wr(8'h1C, 32'h0001_0040);
    check(s_mchg && s_mval == 1'b1, "R8 remask value", {s_mchg, s_mval}, 2'b11);
    @(negedge clk_i); irr_clr_i[5] = 1'b1;
    @(negedge clk_i); irr_clr_i = '0;
    win_wr(8'h1A, 32'h0000_A0F3);
    check(!s_svc, "R10 cleared pending no svc", s_svc, 0);
  endtask

  task automatic t_range;
    logic [31:0] d;
    win_rd(8'h40, d);
    check(d == 32'hFFFF_FFFF, "R6 index 24 reads ones", d, 32'hFFFF_FFFF);
    bus_wr(8'h10, 32'h0000_0000);
    check(!s_tbl && !s_mchg, "R6 write dropped", {s_tbl, s_mchg}, 0);
    win_rd(8'h05, d);
    check(d == 32'hFFFF_FFFF, "R6 low hole reads ones", d, 32'hFFFF_FFFF);
    win_rd(8'h3E, d);
    check(d == 32'h0001_0000, "R6 last entry valid", d, 32'h0001_0000);
    check(entries_o[23*64 +: 64] == 64'h1_0000, "R6 entry23 intact",
          entries_o[23*64 +: 64], 64'h1_0000);
  endtask

  task automatic t_other;
    logic [31:0] d;
    bus_wr(8'h00, 32'h0000_0011);
    bus_rd(8'h20, d);
    check(d == 0, "R11 unused read zero", d, 0);
    bus_wr(8'h40, 32'h0000_0055);
    bus_rd(8'h00, d);
    check(d == 32'h11, "R11 unused write no effect", d, 32'h11);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_select();
    t_version();
    t_id();
    t_entry();
    t_rirr();
    t_service();
    t_range();
    t_other();
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule